// File: doc/BRIEF.md
# Data-Side Address Translation Buffer

This block caches virtual-to-physical mappings for the data stream of a 32-bit processor. It holds a fixed number of fully associative slots. Each slot describes one of three mapping granularities: a 1 MiB section, a 64 KiB large page or a 4 KiB small page. The granularity decides how many upper virtual address bits take part in the tag compare, and how many stored frame bits replace them in the physical address.

A lookup is purely combinational. The requester presents a virtual address and receives, in the same cycle, a hit flag, the translated physical address, a 4-bit domain and two cache/buffer attribute bits. Misses are handled outside the block: an external table walker resolves the mapping and writes it back through the refill port. The slot that receives the refill is picked by a round-robin pointer.

Two maintenance commands keep the cached mappings coherent with the page tables. The first discards every slot. The second discards only the slots whose mapping covers a supplied virtual address.

Top module: `va_xlate_tlb`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses, and the round-robin pointer is at slot 0.
- R2: A slot filled with size code 2'b10 (1 MiB section) hits when virtual bits [31:20] equal the stored ones. Its physical address is stored frame bits [31:20] concatenated with virtual bits [19:0].
- R3: A slot filled with size code 2'b01 (64 KiB large page) compares virtual bits [31:16]. Its physical address is frame bits [31:16] concatenated with virtual bits [15:0].
- R4: A slot filled with size code 2'b00 or 2'b11 (4 KiB small page) compares virtual bits [31:12]. Its physical address is frame bits [31:12] concatenated with virtual bits [11:0]. Frame bits below the page boundary are ignored.
- R5: On a hit the domain and cache/buffer bits stored with the slot are returned. On a miss the hit flag, physical address, domain and attributes are all zero.
- R6: When several valid slots match one address, the lowest-numbered slot supplies the result.
- R7: A refill writes the slot at the pointer and advances the pointer by one modulo 32. The 33rd refill after reset therefore overwrites the first one.
- R8: Flush-all invalidates every slot from the next cycle on. A refill in the same cycle is dropped.
- R9: Flush-single invalidates every valid slot whose mapping, at that slot's own size, covers the supplied virtual address. All other slots keep their contents.
- R10: When a flush-single and a refill occur in the same cycle, the flush is applied first, and the refilled slot is valid afterwards even if it matches the flushed address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated physical address |
| lk_dom | output | 4 | Domain of the hitting slot |
| lk_cb | output | 2 | Cacheable/bufferable bits of the hitting slot |
| fill_en | input | 1 | Write a new mapping at the pointer |
| fill_va | input | 32 | Virtual address of the new mapping |
| fill_pa | input | 32 | Physical frame address of the new mapping |
| fill_size | input | 2 | 2'b10 section, 2'b01 large page, 2'b00/2'b11 small page |
| fill_dom | input | 4 | Domain stored with the new mapping |
| fill_cb | input | 2 | Attribute bits stored with the new mapping |
| inv_all | input | 1 | Invalidate all slots |
| inv_one | input | 1 | Invalidate slots covering inv_va |
| inv_va | input | 32 | Address for single invalidation |

## Verification
Lookups are tried just inside and just outside the region of each mapping size, to separate correct masks from masks that are one nibble too wide or too narrow. Garbage is placed in the low bits of the refill frame and refill virtual address, which shows whether those bits leak into the result. An address covered by both a section and a small page tells priority order apart from an OR of hits. A long refill run that wraps the pointer, plus single flushes that hit two overlapping slots, tells correct replacement and selective invalidation apart from off-by-one pointer or single-slot flush faults.

// File: rtl/va_xlate_tlb.sv
module va_xlate_tlb #(
  parameter int NUM_ENTRIES = 32,
  parameter int ADDR_W      = 32,
  parameter int DOM_W       = 4,
  parameter int ATTR_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_va,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_pa,
  output logic [DOM_W-1:0]  lk_dom,
  output logic [ATTR_W-1:0] lk_cb,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_va,
  input  logic [ADDR_W-1:0] fill_pa,
  input  logic [1:0]        fill_size,
  input  logic [DOM_W-1:0]  fill_dom,
  input  logic [ATTR_W-1:0] fill_cb,
  input  logic              inv_all,
  input  logic              inv_one,
  input  logic [ADDR_W-1:0] inv_va
);

  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam int PN_W  = ADDR_W - 12;
  localparam logic [PN_W-1:0] M_SEC = ~(PN_W'(8'hFF));
  localparam logic [PN_W-1:0] M_LRG = ~(PN_W'(4'hF));
  localparam logic [PN_W-1:0] M_SML = '1;

  logic [PN_W-1:0]   tag_q [NUM_ENTRIES];
  logic [PN_W-1:0]   frm_q [NUM_ENTRIES];
  logic [1:0]        sz_q  [NUM_ENTRIES];
  logic [DOM_W-1:0]  dom_q [NUM_ENTRIES];
  logic [ATTR_W-1:0] cb_q  [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] valid_q;
  logic [IDX_W-1:0]       ptr_q;

  logic [PN_W-1:0]        ent_mask [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] lk_match, inv_match;
  logic [IDX_W-1:0]       sel;

  wire [PN_W-1:0] lk_pn  = lk_va[ADDR_W-1:12];
  wire [PN_W-1:0] inv_pn = inv_va[ADDR_W-1:12];
  wire            do_fill = fill_en && !inv_all;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    assign ent_mask[i]  = (sz_q[i] == 2'b10) ? M_SEC :
                          (sz_q[i] == 2'b01) ? M_LRG : M_SML;
    assign lk_match[i]  = valid_q[i] && (((lk_pn  ^ tag_q[i]) & ent_mask[i]) == '0);
    assign inv_match[i] = valid_q[i] && (((inv_pn ^ tag_q[i]) & ent_mask[i]) == '0);
  end

  always_comb begin
    sel = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (lk_match[i]) sel = IDX_W'(i);
  end

  assign lk_hit = |lk_match;
  assign lk_pa  = lk_hit ? {(frm_q[sel] & ent_mask[sel]) | (lk_pn & ~ent_mask[sel]),
                            lk_va[11:0]} : '0;
  assign lk_dom = lk_hit ? dom_q[sel] : '0;
  assign lk_cb  = lk_hit ? cb_q[sel]  : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (inv_all) begin
      valid_q <= '0;
    end else begin
      if (inv_one) valid_q <= valid_q & ~inv_match;
      if (fill_en) begin
        valid_q[ptr_q] <= 1'b1;
        ptr_q <= (ptr_q == IDX_W'(NUM_ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[ptr_q] <= fill_va[ADDR_W-1:12];
      frm_q[ptr_q] <= fill_pa[ADDR_W-1:12];
      sz_q[ptr_q]  <= fill_size;
      dom_q[ptr_q] <= fill_dom;
      cb_q[ptr_q]  <= fill_cb;
    end
  end

  p_flush_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !lk_hit);

  p_flush_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_one && !inv_all && !fill_en) |=> ((valid_q & $past(inv_match)) == '0));

  p_fill_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    do_fill |=> valid_q[$past(ptr_q)]);

  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    do_fill |=> (ptr_q == (($past(ptr_q) == IDX_W'(NUM_ENTRIES - 1)) ? '0 : $past(ptr_q) + 1'b1)));

  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !do_fill |=> $stable(ptr_q));

endmodule

// File: tb/va_xlate_tlb_tb.sv
`timescale 1ns/1ps
module va_xlate_tlb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_hit;
  logic [31:0] lk_pa;
  logic [3:0]  lk_dom;
  logic [1:0]  lk_cb;
  logic        fill_en = 1'b0;
  logic [31:0] fill_va = '0, fill_pa = '0;
  logic [1:0]  fill_size = '0;
  logic [3:0]  fill_dom = '0;
  logic [1:0]  fill_cb = '0;
  logic        inv_all = 1'b0, inv_one = 1'b0;
  logic [31:0] inv_va = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  va_xlate_tlb u_dut (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa),
    .lk_dom(lk_dom), .lk_cb(lk_cb), .fill_en(fill_en), .fill_va(fill_va),
    .fill_pa(fill_pa), .fill_size(fill_size), .fill_dom(fill_dom), .fill_cb(fill_cb),
    .inv_all(inv_all), .inv_one(inv_one), .inv_va(inv_va));

  // {va, pa, size, dom, cb}; low bits carry junk on purpose
  localparam logic [71:0] FILLS [5] = '{
    {32'h123F_FFFF, 32'hABC1_2345, 2'b10, 4'd3, 2'b11},  // slot 0 section
    {32'h4567_1234, 32'h89AB_FFFF, 2'b01, 4'd5, 2'b01},  // slot 1 large
    {32'h7654_3ABC, 32'h1111_2FFF, 2'b00, 4'd9, 2'b10},  // slot 2 small
    {32'h1234_5000, 32'h2222_2000, 2'b00, 4'd7, 2'b00},  // slot 3 small inside slot 0
    {32'h0000_5FFF, 32'h3333_3000, 2'b11, 4'd1, 2'b00}   // slot 4 code 11 = small
  };

  // {va, hit, pa, dom, cb}
  localparam logic [70:0] LOOKS [10] = '{
    {32'h1230_0000, 1'b1, 32'hABC0_0000, 4'd3, 2'b11},  // R2
    {32'h123F_FFFC, 1'b1, 32'hABCF_FFFC, 4'd3, 2'b11},  // R2 top edge
    {32'h1240_0000, 1'b0, 32'h0,         4'd0, 2'b00},  // R2 outside, R5 miss zero
    {32'h4567_ABCD, 1'b1, 32'h89AB_ABCD, 4'd5, 2'b01},  // R3
    {32'h4568_0000, 1'b0, 32'h0,         4'd0, 2'b00},  // R3 outside
    {32'h7654_3FFF, 1'b1, 32'h1111_2FFF, 4'd9, 2'b10},  // R4
    {32'h7654_4000, 1'b0, 32'h0,         4'd0, 2'b00},  // R4 outside
    {32'h1234_5678, 1'b1, 32'hABC4_5678, 4'd3, 2'b11},  // R6 slot 0 beats slot 3
    {32'h0000_5ABC, 1'b1, 32'h3333_3ABC, 4'd1, 2'b00},  // R4 code 11, R5 attrs
    {32'h0000_6000, 1'b0, 32'h0,         4'd0, 2'b00}   // R4 outside
  };
  localparam int LOOK_REQ [10] = '{2, 2, 2, 3, 3, 4, 4, 6, 4, 4};

  task automatic look(input string req, input logic [31:0] va, input logic ehit,
                      input logic [31:0] epa, input logic [3:0] edom, input logic [1:0] ecb);
    @(negedge clk);
    lk_va = va;
    #1;
    checks++;
    if (lk_hit !== ehit || lk_pa !== epa || lk_dom !== edom || lk_cb !== ecb) begin
      errors++;
      $display("FAIL %s va=%h: got hit=%b pa=%h dom=%h cb=%b, expected hit=%b pa=%h dom=%h cb=%b",
               req, va, lk_hit, lk_pa, lk_dom, lk_cb, ehit, epa, edom, ecb);
    end
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                      input logic [3:0] dom, input logic [1:0] cb);
    @(negedge clk);
    fill_en = 1'b1; fill_va = va; fill_pa = pa; fill_size = sz; fill_dom = dom; fill_cb = cb;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic flush_one(input logic [31:0] va);
    @(negedge clk);
    inv_one = 1'b1; inv_va = va;
    @(negedge clk);
    inv_one = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look("R1", 32'h0000_0000, 1'b0, 32'h0, 4'd0, 2'b00);
    look("R1", 32'h1230_0000, 1'b0, 32'h0, 4'd0, 2'b00);

    for (int i = 0; i < 5; i++)
      fill(FILLS[i][71:40], FILLS[i][39:8], FILLS[i][7:6], FILLS[i][5:2], FILLS[i][1:0]);
    for (int i = 0; i < 10; i++)
      look($sformatf("R%0d", LOOK_REQ[i]), LOOKS[i][70:39], LOOKS[i][38],
           LOOKS[i][37:6], LOOKS[i][5:2], LOOKS[i][1:0]);

    // R9: covers slot 0 (section) and slot 3 (small); slot 1 untouched
    flush_one(32'h1234_5000);
    look("R9", 32'h1234_5678, 1'b0, 32'h0, 4'd0, 2'b00);
    look("R9", 32'h1230_0000, 1'b0, 32'h0, 4'd0, 2'b00);
    look("R9", 32'h4567_0000, 1'b1, 32'h89AB_0000, 4'd5, 2'b01);

    // R7: slots 5..31, then wrap onto slots 0 and 1
    for (int i = 0; i < 27; i++)
      fill(32'h8000_0000 + (i << 12), 32'h6000_0000 + (i << 12), 2'b00, 4'd2, 2'b01);
    look("R7", 32'h8001_A010, 1'b1, 32'h6001_A010, 4'd2, 2'b01);
    look("R7", 32'h4567_0000, 1'b1, 32'h89AB_0000, 4'd5, 2'b01);
    fill(32'hC000_0000, 32'h4444_0000, 2'b00, 4'd4, 2'b10);
    look("R7", 32'h4567_0000, 1'b1, 32'h89AB_0000, 4'd5, 2'b01);
    fill(32'hC000_1000, 32'h4444_1000, 2'b00, 4'd6, 2'b11);
    look("R7", 32'h4567_0000, 1'b0, 32'h0, 4'd0, 2'b00);
    look("R7", 32'hC000_1234, 1'b1, 32'h4444_1234, 4'd6, 2'b11);
    look("R7", 32'h7654_3000, 1'b1, 32'h1111_2000, 4'd9, 2'b10);

    // R10: flush slot 1 and refill slot 2 with the same page in one cycle
    @(negedge clk);
    inv_one = 1'b1; inv_va = 32'hC000_1000;
    fill_en = 1'b1; fill_va = 32'hC000_1000; fill_pa = 32'h5555_5000;
    fill_size = 2'b00; fill_dom = 4'd8; fill_cb = 2'b01;
    @(negedge clk);
    inv_one = 1'b0; fill_en = 1'b0;
    look("R10", 32'hC000_1ABC, 1'b1, 32'h5555_5ABC, 4'd8, 2'b01);
    look("R10", 32'h7654_3000, 1'b0, 32'h0, 4'd0, 2'b00);

    // R8: flush-all wins over a refill in the same cycle
    @(negedge clk);
    inv_all = 1'b1;
    fill_en = 1'b1; fill_va = 32'hD000_0000; fill_pa = 32'h7777_0000;
    fill_size = 2'b10; fill_dom = 4'd2; fill_cb = 2'b11;
    @(negedge clk);
    inv_all = 1'b0; fill_en = 1'b0;
    look("R8", 32'hD000_0000, 1'b0, 32'h0, 4'd0, 2'b00);
    look("R8", 32'h8000_0000, 1'b0, 32'h0, 4'd0, 2'b00);
    look("R8", 32'hC000_1000, 1'b0, 32'h0, 4'd0, 2'b00);

    // R1: reset clears state after use
    fill(32'hE000_0000, 32'h0100_0000, 2'b10, 4'd1, 2'b01);
    look("R2", 32'hE001_2345, 1'b1, 32'h0101_2345, 4'd1, 2'b01);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    look("R1", 32'hE001_2345, 1'b0, 32'h0, 4'd0, 2'b00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule